// File: doc/BRIEF.md
# Card Bus Clock Divider with One-Hot Ratio Select

This block derives the clock for a memory-card bus from the host clock. Software writes a control word that holds a one-hot ratio field, a run bit and a power-save bit. The block sends a divided card clock from a register, so the output cannot glitch. It also gives a one-cycle strobe in the host domain that marks each rising edge of the card clock, which the card-side shift logic uses as its clock enable.

The ratio field is one-hot. When no bit is set, the divider runs at half the host rate. Bit k alone gives a ratio of 2^(k+2). With a host clock near 67 MHz, the bit that gives divide-by-256 produces roughly 262 kHz, which suits card identification. New settings are taken only at the end of a low phase, so a high or low pulse is never cut short. In power-save mode the clock parks low while the transfer engine reports idle, and it resumes when the engine becomes busy.

Top module: `card_clk_div`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `card_clk` and `card_rise` are 0.
- R2: With the select field (ctrl bits SEL_W-1..0) all zero and the run bit (ctrl bit SEL_W) set, `card_clk` has a period of 2 host cycles: 1 cycle high, then 1 cycle low.
- R3: With only select bit k set, the period is 2^(k+2) host cycles, high for the first half and low for the second half.
- R4: When several select bits are set, the lowest set bit alone sets the ratio.
- R5: When the run bit is clear, `card_clk` stays low and `card_rise` stays 0 once the period in progress ends.
- R6: When power save (ctrl bit SEL_W+1) is set and `eng_idle` is 1, the clock parks low after the period in progress. When `eng_idle` is 0, or when power save is clear, `eng_idle` has no effect.
- R7: A change of ratio or run state takes effect only at the end of a low phase. Every high phase lasts half the ratio that was in force at its rising edge, and so does the low phase that follows it.
- R8: `card_rise` is 1 in exactly those host cycles in which `card_clk` has just gone from 0 to 1.
- R9: From the parked state, the first host clock edge that samples the run condition as true drives `card_clk` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ctrl | input | SEL_W+2 | Control word: one-hot select [SEL_W-1:0], run [SEL_W], power save [SEL_W+1] |
| eng_idle | input | 1 | Transfer engine idle indication |
| card_clk | output | 1 | Divided card bus clock, driven from a register |
| card_rise | output | 1 | One-cycle strobe on each rising edge of card_clk |

## Verification
The bench builds the block with the default SEL_W of 8. With that width every ratio from 2 to 512 can be reached, including the slowest setting of 512 host cycles per period. That matters for the ratio-change test: a switch from 512 down to 2 is made right at a rising edge, so a shortened 256-cycle high phase would be visible. A behavioural model tracks the position within each period as an integer and is compared with both outputs on every cycle. Directed measurements of high width and period, parking windows and restart latency add to that comparison.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // Half-period length in host cycles for an isolated one-hot select value.
  // An empty select means divide by two, so one host cycle per phase.
  function automatic logic [31:0] half_count(input logic [31:0] lowest);
    if (lowest == 32'd0) return 32'd1;
    return lowest << 1;
  endfunction

  // The clock may start a new period only when enabled and not parked by power save.
  function automatic logic run_allowed(input logic en, input logic pwr_save, input logic idle);
    return en & ~(pwr_save & idle);
  endfunction

endpackage

// File: rtl/cdiv_ratio_dec.sv
module cdiv_ratio_dec #(
  parameter int SEL_W  = 8,
  parameter int HALF_W = SEL_W + 1
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [SEL_W-1:0]  lowest,
  output logic [HALF_W-1:0] half
);
  // below[k] is set when any select bit under position k is set
  logic [SEL_W:0] below;
  logic [31:0]    half_full;

  assign below[0] = 1'b0;

  for (genvar k = 0; k < SEL_W; k++) begin : g_pick
    assign lowest[k]  = sel[k] & ~below[k];
    assign below[k+1] = below[k] | sel[k];
  end

  assign half_full = cdiv_pkg::half_count(32'(lowest));
  assign half      = half_full[HALF_W-1:0];

endmodule

// File: rtl/cdiv_run_gate.sv
module cdiv_run_gate (
  input  logic en,
  input  logic pwr_save,
  input  logic idle,
  output logic run
);
  assign run = cdiv_pkg::run_allowed(en, pwr_save, idle);
endmodule

// File: rtl/cdiv_phase_gen.sv
module cdiv_phase_gen #(
  parameter int HALF_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] new_half,
  output logic              card_clk,
  output logic              card_rise,
  output logic              boundary
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] act_half_q;
  logic [HALF_W-1:0] last;
  logic              clk_q;
  logic              rise_q;
  logic              park_q;
  logic              phase_end;
  logic [HALF_W-1:0] hi_len_q;

  assign last      = act_half_q - 1'b1;
  assign phase_end = (cnt_q == last);
  // A low phase has ended, or the clock is parked: new settings may load here.
  assign boundary  = ~clk_q & (park_q | phase_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q      <= 1'b0;
      rise_q     <= 1'b0;
      park_q     <= 1'b1;
      cnt_q      <= '0;
      act_half_q <= HALF_W'(1);
    end else begin
      rise_q <= 1'b0;
      if (clk_q) begin
        if (phase_end) begin
          clk_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (boundary) begin
        if (run) begin
          clk_q      <= 1'b1;
          rise_q     <= 1'b1;
          park_q     <= 1'b0;
          cnt_q      <= '0;
          act_half_q <= new_half;
        end else begin
          park_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Width of the current high phase, kept for the width assertion.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_len_q <= '0;
    end else if (boundary && run) begin
      hi_len_q <= HALF_W'(1);
    end else if (clk_q && !phase_end) begin
      hi_len_q <= hi_len_q + 1'b1;
    end
  end

  assign card_clk  = clk_q;
  assign card_rise = rise_q;

  AST_RISE_IS_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> rise_q); // R8
  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (clk_q && !$past(clk_q))); // R8
  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_q) |-> (hi_len_q == act_half_q)); // R7
  AST_RATIO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_q && $past(clk_q)) |-> $stable(act_half_q)); // R7
  AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> $past(run)); // R5

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int SEL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W+1:0]   ctrl,
  input  logic               eng_idle,
  output logic               card_clk,
  output logic               card_rise
);
  localparam int HALF_W = SEL_W + 1;
  localparam int EN_BIT = SEL_W;
  localparam int PS_BIT = SEL_W + 1;

  logic [SEL_W-1:0]  sel;
  logic [SEL_W-1:0]  sel_lowest;
  logic [HALF_W-1:0] sel_half;
  logic              run;
  logic              boundary;

  assign sel = ctrl[SEL_W-1:0];

  cdiv_ratio_dec #(.SEL_W(SEL_W), .HALF_W(HALF_W)) u_dec (
    .sel    (sel),
    .lowest (sel_lowest),
    .half   (sel_half)
  );

  cdiv_run_gate u_gate (
    .en       (ctrl[EN_BIT]),
    .pwr_save (ctrl[PS_BIT]),
    .idle     (eng_idle),
    .run      (run)
  );

  cdiv_phase_gen #(.HALF_W(HALF_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .new_half  (sel_half),
    .card_clk  (card_clk),
    .card_rise (card_rise),
    .boundary  (boundary)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_lowest)); // R4
  AST_SEL_PICKS_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|sel) |-> ((sel_lowest & sel) != '0)); // R4
  AST_PARK_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !run) |=> !card_clk); // R6

endmodule

// File: tb/test_card_clk_div.sv
`timescale 1ns/1ps
module test_card_clk_div;
  localparam int SEL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SEL_W+1:0] ctrl = '0;
  logic             eng_idle = 1'b0;
  logic             card_clk;
  logic             card_rise;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  card_clk_div #(.SEL_W(SEL_W)) i_card_clk_div (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .eng_idle(eng_idle),
    .card_clk(card_clk), .card_rise(card_rise)
  );

  // Ratio from the requirements: lowest set select bit k gives 2^(k+2), none gives 2.
  function automatic int ratio_of(input logic [SEL_W-1:0] s);
    for (int k = 0; k < SEL_W; k++) if (s[k]) return 1 << (k + 2);
    return 2;
  endfunction

  // Behavioural model: position inside the current period, or parked.
  int m_pos = 0;
  int m_ratio = 2;
  bit m_parked = 1'b1;
  bit m_clk = 1'b0;
  bit m_rise = 1'b0;

  always @(posedge clk) begin
    bit go;
    go = ctrl[SEL_W] && !(ctrl[SEL_W+1] && eng_idle);
    m_rise = 1'b0;
    if (!rst_n) begin
      m_parked = 1'b1;
      m_pos = 0;
    end else begin
      if (!m_parked) m_pos++;
      if (m_parked || m_pos == m_ratio) begin
        if (go) begin
          m_ratio = ratio_of(ctrl[SEL_W-1:0]);
          m_pos = 0;
          m_parked = 1'b0;
          m_rise = 1'b1;
        end else begin
          m_parked = 1'b1;
        end
      end
    end
    m_clk = !m_parked && (m_pos < m_ratio / 2);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(card_clk == m_clk, "R7 waveform vs model", card_clk, m_clk);
      chk(card_rise == m_rise, "R8 strobe vs model", card_rise, m_rise);
    end
  end

  // Starts at a negedge, syncs to a rise, returns high width and period.
  task automatic measure(output int hi, output int per);
    int guard = 0;
    while (!card_rise && guard < 4000) begin @(negedge clk); guard++; end
    hi = 0; per = 0;
    do begin hi++; per++; @(negedge clk); end while (card_clk && per < 4000);
    while (!card_rise && per < 4000) begin per++; @(negedge clk); end
  endtask

  task automatic set_ctrl(input logic ps, input logic en, input logic [SEL_W-1:0] s);
    ctrl = {ps, en, s};
  endtask

  task automatic count_rises(input int n, output int rises, output int highs);
    rises = 0; highs = 0;
    repeat (n) begin
      @(negedge clk);
      if (card_rise) rises++;
      if (card_clk) highs++;
    end
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int hi, per, r, h;
    @(negedge clk);
    @(negedge clk);
    chk(card_clk == 1'b0, "R1 clk in reset", card_clk, 0);
    chk(card_rise == 1'b0, "R1 strobe in reset", card_rise, 0);
    set_ctrl(1'b0, 1'b1, '0);
    rst_n = 1'b1;
    chk(card_clk == 1'b0, "R1 clk after reset", card_clk, 0);

    measure(hi, per); measure(hi, per);
    chk(hi == 1, "R2 high width /2", hi, 1);
    chk(per == 2, "R2 period /2", per, 2);

    for (int k = 0; k < SEL_W; k++) begin
      set_ctrl(1'b0, 1'b1, SEL_W'(1) << k);
      measure(hi, per); measure(hi, per); measure(hi, per);
      chk(per == (1 << (k + 2)), "R3 period one-hot", per, 1 << (k + 2));
      chk(hi == (1 << (k + 1)), "R3 high half", hi, 1 << (k + 1));
    end

    set_ctrl(1'b0, 1'b1, 8'b0010_1100);
    measure(hi, per); measure(hi, per); measure(hi, per);
    chk(per == 16, "R4 lowest of 0x2C", per, 16);
    set_ctrl(1'b0, 1'b1, 8'hF0);
    measure(hi, per); measure(hi, per); measure(hi, per);
    chk(per == 64, "R4 lowest of 0xF0", per, 64);

    // Ratio change at a rising edge: the running period keeps its length.
    set_ctrl(1'b0, 1'b1, 8'h80);
    measure(hi, per); measure(hi, per);
    set_ctrl(1'b0, 1'b1, '0);
    measure(hi, per);
    chk(hi == 256, "R7 high not shortened", hi, 256);
    chk(per == 512, "R7 period kept", per, 512);
    measure(hi, per);
    chk(per == 2, "R7 new ratio next period", per, 2);

    // Run bit cleared.
    set_ctrl(1'b0, 1'b0, 8'h01);
    repeat (20) @(negedge clk);
    count_rises(300, r, h);
    chk(r == 0, "R5 no strobe when off", r, 0);
    chk(h == 0, "R5 clock low when off", h, 0);

    // Restart latency from parked.
    set_ctrl(1'b0, 1'b1, 8'h01);
    @(negedge clk);
    chk(card_rise == 1'b1, "R9 strobe one edge after run", card_rise, 1);
    chk(card_clk == 1'b1, "R9 clock high one edge after run", card_clk, 1);

    // Power save with idle engine parks the clock.
    eng_idle = 1'b1;
    set_ctrl(1'b1, 1'b1, 8'h01);
    repeat (20) @(negedge clk);
    count_rises(200, r, h);
    chk(r == 0, "R6 parked while idle", r, 0);
    chk(h == 0, "R6 low while idle", h, 0);
    eng_idle = 1'b0;
    @(negedge clk);
    chk(card_rise == 1'b1, "R9 resume on busy", card_rise, 1);
    measure(hi, per); measure(hi, per);
    chk(per == 4, "R6 runs when busy", per, 4);
    eng_idle = 1'b1;
    set_ctrl(1'b0, 1'b1, 8'h02);
    measure(hi, per); measure(hi, per);
    chk(per == 8, "R6 idle ignored without power save", per, 8);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule